// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block decides, cycle by cycle, when the gate of one synchronous-rectifier switch is driven. It watches four drain-voltage comparator flags: below the turn-on level, above the turn-off level, above the high-detect level and above the forced-off level. It also watches the gate state of the opposite channel. A turn-on needs the drain held low through a debounce period. Turn-off normally follows the turn-off comparator, but that comparator is ignored during a blanking window. The window is scaled from the conduction time measured in the previous cycle.

While the gate is on, a turn-off flag that is held too long inside the blanking window is taken as reverse current. The gate then drops at once, and the next turn-ons use a much longer debounce until enough clean cycles have passed. Two fixed guards stay in force throughout: a maximum on-time, and an unconditional forced-off level. All durations are counted on a 100 MHz clock.

Top module: `sr_gate_seq`

## Requirements
- R1: After reset `gate_o` is low, the previous conduction time is 480 cycles and the long-debounce mode is off.
- R2: With the opposite gate low and the block armed, `gate_o` rises on the 9th consecutive clock edge at which `vd_below_on_i` is sampled high (8-cycle debounce). A low sample in between restarts the count.
- R3: Turn-on is blocked while `opp_gate_i` is high. It is also blocked for 20 edges starting at the first edge that samples `opp_gate_i` low. With `vd_below_on_i` held high, `gate_o` rises on the 29th edge counted from that edge.
- R4: Conduction time T is the number of edges from the gate rising to the first edge that samples `vd_above_high_i` high. The blanking length is T/4 (right shift by 2), clamped to 20..120 cycles. `vd_above_off_i` has no turn-off effect while the gate has been high for fewer cycles than the blanking length.
- R5: Outside the other cases, `gate_o` falls at the first edge where `vd_above_off_i` is high and the gate has been high for at least the blanking length.
- R6: If `vd_above_off_i` stays high during blanking for max(T/16, 1) consecutive samples (right shift by 4), `gate_o` falls at that edge. The following turn-ons use an 85-cycle debounce, so the gate rises on the 86th low-drain edge.
- R7: The long debounce stays in force until 7 consecutive gate cycles end without inversion. The 8th turn-on uses the short debounce again.
- R8: `gate_o` never stays high for more than 1500 cycles. With no other turn-off cause it falls after exactly 1500 cycles.
- R9: `vd_above_force_i` sampled high while the gate is on turns the gate off at that edge, even inside blanking.
- R10: After a turn-off the block re-arms only on an edge that samples `vd_above_high_i` high. Until then `vd_below_on_i` has no effect.
- R11: The first gate cycle after reset uses a 120-cycle blanking length, derived from the reset conduction time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 100 MHz clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vd_below_on_i | input | 1 | Drain below the turn-on threshold |
| vd_above_off_i | input | 1 | Drain above the turn-off threshold |
| vd_above_high_i | input | 1 | Drain above the high-detect threshold |
| vd_above_force_i | input | 1 | Drain above the forced-off level |
| opp_gate_i | input | 1 | Gate state of the opposite channel |
| gate_o | output | 1 | Gate command |

## Verification
The bench measures the blanking boundary exactly, one cycle before and at the edge where a held turn-off flag takes effect. It does this after conduction times that land in the middle of the scaling range and at both clamp limits. A design that got the shift or the clamps wrong would drop the gate one or more cycles early or late. The inversion window is driven to its exact length, and the long-debounce mode is followed across its full exit count. An off-by-one clean counter would show up as a short or long debounce on the 7th or 8th cycle. The lockout, the re-arm gate, forced turn-off inside blanking and the 1500-cycle limit are each checked at their edge cycle. A design that measured any of these windows from the wrong edge would move the gate by a cycle.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEB  = 2'd1,
    ST_ON   = 2'd2,
    ST_WAIT = 2'd3
  } sr_state_e;
endpackage

// File: rtl/sr_lockout.sv
module sr_lockout #(
  parameter int unsigned LOCK_CYC = 20,
  localparam int LK_W = $clog2(LOCK_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic opp_gate_i,
  output logic lock_o
);
  logic            opp_q;
  logic [LK_W-1:0] lock_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opp_q    <= 1'b0;
      lock_cnt <= '0;
    end else begin
      opp_q <= opp_gate_i;
      if (opp_q && !opp_gate_i) lock_cnt <= LK_W'(LOCK_CYC - 1);
      else if (lock_cnt != '0)  lock_cnt <= lock_cnt - 1'b1;
    end
  end

  // falling edge itself counts as the first blocked cycle
  assign lock_o = opp_gate_i | opp_q | (lock_cnt != '0);

  p_lock_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_cnt <= LK_W'(LOCK_CYC - 1));
  p_lock_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(opp_gate_i) |-> lock_o);
endmodule

// File: rtl/sr_cond_meter.sv
module sr_cond_meter #(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned PREV_RST = 480
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             high_i,
  output logic [CNT_W-1:0] prev_o
);
  logic             meas_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meas_q <= 1'b0;
      cnt_q  <= '0;
      prev_o <= CNT_W'(PREV_RST);
    end else if (start_i) begin
      meas_q <= 1'b1;
      cnt_q  <= CNT_W'(1);
    end else if (meas_q) begin
      if (high_i) begin
        prev_o <= cnt_q;
        meas_q <= 1'b0;
      end else if (cnt_q != '1) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_prev_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_o != '0);
  p_latch_on_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_q && high_i && !start_i) |=> !meas_q);
endmodule

// File: rtl/sr_window_calc.sv
module sr_window_calc #(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned MIN_LO    = 20,
  parameter int unsigned MIN_HI    = 120,
  parameter int unsigned MIN_SHIFT = 2,
  parameter int unsigned INV_SHIFT = 4
) (
  input  logic [CNT_W-1:0] prev_i,
  output logic [CNT_W-1:0] min_on_o,
  output logic [CNT_W-1:0] inv_thr_o
);
  logic [CNT_W-1:0] min_raw;
  logic [CNT_W-1:0] inv_raw;

  always_comb begin
    min_raw = prev_i >> MIN_SHIFT;
    inv_raw = prev_i >> INV_SHIFT;
    if (min_raw < CNT_W'(MIN_LO))      min_on_o = CNT_W'(MIN_LO);
    else if (min_raw > CNT_W'(MIN_HI)) min_on_o = CNT_W'(MIN_HI);
    else                               min_on_o = min_raw;
    inv_thr_o = (inv_raw == '0) ? CNT_W'(1) : inv_raw;
  end
endmodule

// File: rtl/sr_inv_tracker.sv
module sr_inv_tracker #(
  parameter int unsigned CLEAN_CYC = 7,
  localparam int CL_W = $clog2(CLEAN_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inv_evt_i,
  input  logic clean_evt_i,
  output logic inv_mode_o
);
  logic [CL_W-1:0] clean_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_mode_o <= 1'b0;
      clean_cnt  <= '0;
    end else if (inv_evt_i) begin
      inv_mode_o <= 1'b1;
      clean_cnt  <= '0;
    end else if (clean_evt_i && inv_mode_o) begin
      if (clean_cnt == CL_W'(CLEAN_CYC - 1)) begin
        inv_mode_o <= 1'b0;
        clean_cnt  <= '0;
      end else begin
        clean_cnt <= clean_cnt + 1'b1;
      end
    end
  end

  p_clean_lim_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clean_cnt < CL_W'(CLEAN_CYC));
  p_inv_enter_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_evt_i |=> inv_mode_o);
endmodule

// File: rtl/sr_gate_seq.sv
module sr_gate_seq
  import sr_seq_pkg::*;
#(
  parameter int unsigned DEB_SHORT = 8,
  parameter int unsigned DEB_LONG  = 85,
  parameter int unsigned LOCK_CYC  = 20,
  parameter int unsigned MIN_ON_LO = 20,
  parameter int unsigned MIN_ON_HI = 120,
  parameter int unsigned MAX_ON    = 1500,
  parameter int unsigned CLEAN_CYC = 7,
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned PREV_RST  = 480
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vd_below_on_i,
  input  logic vd_above_off_i,
  input  logic vd_above_high_i,
  input  logic vd_above_force_i,
  input  logic opp_gate_i,
  output logic gate_o
);
  localparam int DEB_W = $clog2(DEB_LONG + 1);

  sr_state_e        state_q;
  logic [DEB_W-1:0] deb_cnt;
  logic [CNT_W-1:0] on_cnt;
  logic [CNT_W-1:0] inv_run;
  logic [CNT_W-1:0] prev_cond;
  logic [CNT_W-1:0] min_on;
  logic [CNT_W-1:0] inv_thr;
  logic [DEB_W-1:0] deb_last;
  logic             lock;
  logic             inv_mode;
  logic             deb_go;
  logic             inv_hit;
  logic             norm_off;
  logic             max_off;
  logic             gate_off;

  sr_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk_i, .rst_ni, .opp_gate_i, .lock_o(lock)
  );

  sr_cond_meter #(.CNT_W(CNT_W), .PREV_RST(PREV_RST)) u_meter (
    .clk_i, .rst_ni, .start_i(deb_go), .high_i(vd_above_high_i), .prev_o(prev_cond)
  );

  sr_window_calc #(.CNT_W(CNT_W), .MIN_LO(MIN_ON_LO), .MIN_HI(MIN_ON_HI)) u_win (
    .prev_i(prev_cond), .min_on_o(min_on), .inv_thr_o(inv_thr)
  );

  sr_inv_tracker #(.CLEAN_CYC(CLEAN_CYC)) u_inv (
    .clk_i, .rst_ni,
    .inv_evt_i  (state_q == ST_ON && inv_hit),
    .clean_evt_i(state_q == ST_ON && gate_off && !inv_hit),
    .inv_mode_o (inv_mode)
  );

  always_comb begin
    deb_last = inv_mode ? DEB_W'(DEB_LONG - 1) : DEB_W'(DEB_SHORT - 1);
    deb_go   = (state_q == ST_DEB) && vd_below_on_i && !lock && (deb_cnt == deb_last);
    // on_cnt = cycles the gate has been high, including this one
    inv_hit  = vd_above_off_i && (on_cnt < min_on) && ((inv_run + CNT_W'(1)) >= inv_thr);
    norm_off = vd_above_off_i && (on_cnt >= min_on);
    max_off  = on_cnt >= CNT_W'(MAX_ON);
    gate_off = vd_above_force_i | max_off | inv_hit | norm_off;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      deb_cnt <= '0;
      on_cnt  <= '0;
      inv_run <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (vd_below_on_i && !lock) begin
            state_q <= ST_DEB;
            deb_cnt <= '0;
          end
        end
        ST_DEB: begin
          if (!vd_below_on_i || lock) begin
            state_q <= ST_IDLE;
          end else if (deb_go) begin
            state_q <= ST_ON;
            on_cnt  <= CNT_W'(1);
            inv_run <= '0;
          end else begin
            deb_cnt <= deb_cnt + 1'b1;
          end
        end
        ST_ON: begin
          if (gate_off) begin
            state_q <= ST_WAIT;
          end else begin
            on_cnt  <= on_cnt + 1'b1;
            inv_run <= vd_above_off_i ? inv_run + 1'b1 : '0;
          end
        end
        ST_WAIT: begin
          if (vd_above_high_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign gate_o = (state_q == ST_ON);

  p_on_needs_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(vd_below_on_i));
  p_no_rise_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> !$past(lock));
  p_blank_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_o) |-> ($past(vd_above_force_i) || $past(on_cnt) >= CNT_W'(MAX_ON)
                       || $past(on_cnt) >= $past(min_on) || $past(inv_hit)));
  p_max_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> on_cnt <= CNT_W'(MAX_ON));
  p_force_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && vd_above_force_i) |=> !gate_o);
  p_rearm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !vd_above_high_i) |=> !gate_o);
endmodule

// File: tb/sr_gate_seq_test.sv
module sr_gate_seq_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni, below, aoff, ahigh, aforce, opp, gate;
  int   n_chk  = 0;
  int   n_fail = 0;
  int   prev_t = 480;

  sr_gate_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .vd_below_on_i(below), .vd_above_off_i(aoff),
    .vd_above_high_i(ahigh), .vd_above_force_i(aforce), .opp_gate_i(opp), .gate_o(gate)
  );

  function automatic int exp_min(int t);
    int m;
    m = t >> 2;
    if (m < 20)  m = 20;
    if (m > 120) m = 120;
    return m;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic turn_on(input int lim, input string tag);
    @(negedge clk) below = 1'b1;
    repeat (lim) @(negedge clk);
    chk(gate, 1'b0, tag, "gate before debounce end");
    @(negedge clk);
    chk(gate, 1'b1, tag, "gate after debounce");
    below = 1'b0;
  endtask

  // called at the first negedge with the gate high
  task automatic finish_cycle(input int k_off, input int k_high, input string tag);
    int mn;
    int off_at;
    mn     = exp_min(prev_t);
    off_at = (k_off + 1 > mn) ? k_off + 1 : mn;
    repeat (k_off) @(negedge clk);
    aoff = 1'b1;
    repeat (off_at - 1 - k_off) @(negedge clk);
    chk(gate, 1'b1, tag, "gate held through blanking");
    @(negedge clk);
    chk(gate, 1'b0, tag, "gate off after blanking");
    aoff = 1'b0;
    repeat (k_high - off_at) @(negedge clk);
    ahigh = 1'b1;
    @(negedge clk) ahigh = 1'b0;
    prev_t = k_high + 1;
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; below = 0; aoff = 0; ahigh = 0; aforce = 0; opp = 0;
    repeat (3) @(negedge clk);
    chk(gate, 1'b0, "R1", "gate in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk(gate, 1'b0, "R1", "gate after reset");
  endtask

  task automatic t_short_debounce;
    @(negedge clk) below = 1'b1;
    repeat (4) @(negedge clk);
    below = 1'b0;
    @(negedge clk);
    chk(gate, 1'b0, "R2", "aborted debounce");
    turn_on(8, "R2");
    finish_cycle(118, 199, "R11");
  endtask

  task automatic t_scaling;
    turn_on(8, "R2");
    finish_cycle(47, 999, "R4");
    turn_on(8, "R2");
    finish_cycle(117, 299, "R4");
  endtask

  task automatic t_force;
    turn_on(8, "R9");
    repeat (5) @(negedge clk);
    chk(gate, 1'b1, "R9", "gate before force");
    aforce = 1'b1;
    @(negedge clk);
    chk(gate, 1'b0, "R9", "forced off inside blanking");
    aforce = 1'b0;
    repeat (33) @(negedge clk);
    ahigh = 1'b1;
    @(negedge clk) ahigh = 1'b0;
    prev_t = 40;
  endtask

  task automatic t_clamp_low;
    turn_on(8, "R4");
    finish_cycle(18, 60, "R4");
  endtask

  task automatic t_rearm;
    turn_on(8, "R10");
    repeat (19) @(negedge clk);
    aoff = 1'b1;
    @(negedge clk);
    chk(gate, 1'b0, "R5", "off at blanking end");
    aoff = 1'b0;
    below = 1'b1;
    repeat (30) @(negedge clk);
    chk(gate, 1'b0, "R10", "no turn-on before high detect");
    ahigh = 1'b1;
    @(negedge clk) ahigh = 1'b0;
    prev_t = 51;
    repeat (8) @(negedge clk);
    chk(gate, 1'b0, "R10", "debounce after re-arm");
    @(negedge clk);
    chk(gate, 1'b1, "R10", "turn-on after re-arm");
    below = 1'b0;
    finish_cycle(24, 199, "R5");
  endtask

  task automatic t_lockout;
    @(negedge clk) begin opp = 1'b1; below = 1'b1; end
    repeat (40) @(negedge clk);
    chk(gate, 1'b0, "R3", "blocked while opposite on");
    opp = 1'b0;
    repeat (28) @(negedge clk);
    chk(gate, 1'b0, "R3", "blocked during lockout");
    @(negedge clk);
    chk(gate, 1'b1, "R3", "turn-on after lockout");
    below = 1'b0;
    finish_cycle(49, 199, "R3");
  endtask

  task automatic t_inversion;
    turn_on(8, "R6");
    aoff = 1'b1;
    repeat (11) @(negedge clk);
    chk(gate, 1'b1, "R6", "gate before inversion window");
    @(negedge clk);
    chk(gate, 1'b0, "R6", "inversion turn-off");
    aoff = 1'b0;
    repeat (287) @(negedge clk);
    ahigh = 1'b1;
    @(negedge clk) ahigh = 1'b0;
    prev_t = 300;
    turn_on(85, "R6");
    finish_cycle(73, 299, "R6");
  endtask

  task automatic t_inv_exit;
    for (int i = 0; i < 6; i++) begin
      turn_on(85, "R7");
      finish_cycle(73, 299, "R7");
    end
    turn_on(8, "R7");
    finish_cycle(73, 299, "R7");
  endtask

  task automatic t_max_on;
    turn_on(8, "R8");
    repeat (1499) @(negedge clk);
    chk(gate, 1'b1, "R8", "gate before max on-time");
    @(negedge clk);
    chk(gate, 1'b0, "R8", "gate at max on-time");
    repeat (100) @(negedge clk);
    ahigh = 1'b1;
    @(negedge clk) ahigh = 1'b0;
    prev_t = 1601;
  endtask

  initial begin
    t_reset;
    t_short_debounce;
    t_scaling;
    t_force;
    t_clamp_low;
    t_rearm;
    t_lockout;
    t_inversion;
    t_inv_exit;
    t_max_on;
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule